// File: doc/BRIEF.md
# Multiplexed Address Latch and Bank Select Decoder

This block sits between a processor whose upper address byte shares pins with the lower byte on a time-multiplexed bus and a bank of up to four memory devices. A strobe input opens a set of level-sensitive latches. While the strobe is high the latches are transparent. When it falls they keep the upper address. Four of the latched bits leave the block as high-order address lines for the memories. The remaining two latched bits choose one of four active-low device selects.

The selects are gated combinationally, downstream of the latches, by an active-low enable. A build-time option adds a second gate, driven by the active-low read and write strobes. With that option the selects stay inactive unless at least one of the two strobes is asserted. If the latch strobe is held high permanently, the latches simply follow their inputs and the block works as a plain decoder for a non-multiplexed bus. The latches have no reset. Their content is whatever was last captured.

Top module: `mux_addr_decoder`

## Requirements
- R1: While `addr_le` is 1 the latches are transparent: `hi_addr` equals `ma[3:0]`, and the selects follow `ma[5:4]`, in the same cycle.
- R2: While `addr_le` is 0, a change on `ma` has no effect: `hi_addr` and `sel_n` keep the values held when `addr_le` fell, for unchanged enables.
- R3: `hi_addr[i]` carries latched address bit `ma[i]` for i = 0..3, whatever the values of `ce_n`, `rd_n` and `wr_n`.
- R4: With the selects enabled, the latched value k = {ma[5], ma[4]} drives `sel_n[k]` to 0 and the other three select bits to 1.
- R5: With `ce_n` = 1, `sel_n` is 4'b1111 whatever the address or strobes.
- R6: `ce_n` acts on `sel_n` directly, not through the latches: toggling it while `addr_le` = 0 switches the selects between all-high and the decode of the held address.
- R7: With `USE_STROBES` = 1, `sel_n` is 4'b1111 when `rd_n` = 1 and `wr_n` = 1. If either strobe is 0, the selects are enabled, subject to `ce_n`.
- R8: With `USE_STROBES` = 0, `rd_n` and `wr_n` have no effect, and the selects depend only on `ce_n` and the latched `ma[5:4]`.
- R9: At no time is more than one bit of `sel_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_le | input | 1 | Latch strobe. Latches are transparent when 1 and hold when 0 |
| ma | input | 6 | Multiplexed upper address inputs |
| ce_n | input | 1 | Active-low enable for the selects |
| rd_n | input | 1 | Active-low read strobe (gates the selects when USE_STROBES = 1) |
| wr_n | input | 1 | Active-low write strobe (gates the selects when USE_STROBES = 1) |
| hi_addr | output | 4 | Latched high-order address lines |
| sel_n | output | 4 | Active-low one-hot device selects |

## Verification
The checker follows the select outputs through every settle of the logic. It checks that they are never more than one-hot low, that they are all high whenever the enable or the strobe gate is off, and that they match the latched bank bits whenever they are enabled. It also checks that the address lines track the inputs while the strobe is open. Whether the latches truly hold after the strobe falls can only be shown by the bench's scenarios: these toggle every address and enable pattern during the hold phase and compare the outputs against the value the reference captured. Only the bench can also show that the strobe inputs are ignored in the build without strobe gating.

// File: rtl/mad_pkg.sv
// Package: shared widths for the multiplexed address latch decoder.
// Assumes: a power-of-two number of device selects, addressed by the top latched bits.
package mad_pkg;
    // Number of latched address bits handed to the memories directly
    localparam int HI_W     = 4;
    // Number of latched address bits decoded into selects
    localparam int BANK_W   = 2;
    // Total latched width
    localparam int ADDR_W   = HI_W + BANK_W;
    // Number of device selects
    localparam int N_SEL    = 1 << BANK_W;

    // Gating mode picked at build time
    typedef enum logic [0:0] {
        GATE_CE_ONLY = 1'b0,
        GATE_CE_STB  = 1'b1
    } gate_mode_e;
endpackage

// File: rtl/mad_latch.sv
// Module: bank of level-sensitive address latches.
// Transparent while le is 1, holds while le is 0. Has no reset, by design.
module mad_latch #(
    parameter int W = 6
) (
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One transparent latch per address bit
        always_latch begin
            if (le) q[i] = d[i];
        end
    end
endmodule

// File: rtl/mad_decode.sv
// Module: binary to one-hot active-low decoder.
// Assumes the code is already latched and stable, and adds no gating.
module mad_decode #(
    parameter int CODE_W = 2,
    localparam int N_OUT = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_OUT-1:0]  hit_n
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        // Output k goes low when the code equals k
        assign hit_n[k] = (code != CODE_W'(k));
    end
endmodule

// File: rtl/mad_gate.sv
// Module: select gating by the enable and, optionally, by the read/write strobes.
// Purely combinational, outside the latches. The strobe gate is built only when
// MODE selects it.
module mad_gate #(
    parameter int N = 4,
    parameter mad_pkg::gate_mode_e MODE = mad_pkg::GATE_CE_STB
) (
    input  logic [N-1:0] hit_n,
    input  logic         ce_n,
    input  logic         rd_n,
    input  logic         wr_n,
    output logic [N-1:0] sel_n
);
    logic open_gate;

    if (MODE == mad_pkg::GATE_CE_STB) begin : g_stb
        // Gate open when enabled and at least one strobe is asserted
        assign open_gate = !ce_n && !(rd_n && wr_n);
    end else begin : g_ce
        // Strobes are not part of this variant
        logic unused_stb;
        assign unused_stb = rd_n ^ wr_n;
        assign open_gate  = !ce_n;
    end

    // Closed gate forces every select inactive
    assign sel_n = open_gate ? hit_n : '1;
endmodule

// File: rtl/mux_addr_decoder.sv
// Module: top of the multiplexed address latch and bank select decoder.
// Latches the upper address on addr_le, drives the high-order address lines and
// gates a one-hot active-low select. Assumes ma is stable around the falling
// edge of addr_le.
module mux_addr_decoder #(
    parameter bit USE_STROBES = 1'b1
) (
    input  logic                     addr_le,
    input  logic [mad_pkg::ADDR_W-1:0] ma,
    input  logic                     ce_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    output logic [mad_pkg::HI_W-1:0]  hi_addr,
    output logic [mad_pkg::N_SEL-1:0] sel_n
);
    import mad_pkg::*;

    localparam gate_mode_e MODE = USE_STROBES ? GATE_CE_STB : GATE_CE_ONLY;

    logic [ADDR_W-1:0] lat_q;
    logic [N_SEL-1:0]  hit_n;

    mad_latch #(.W(ADDR_W)) u_latch (
        .le (addr_le),
        .d  (ma),
        .q  (lat_q)
    );

    mad_decode #(.CODE_W(BANK_W)) u_decode (
        .code  (lat_q[ADDR_W-1:HI_W]),
        .hit_n (hit_n)
    );

    mad_gate #(.N(N_SEL), .MODE(MODE)) u_gate (
        .hit_n (hit_n),
        .ce_n  (ce_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .sel_n (sel_n)
    );

    // Low latched bits go straight out as address lines
    assign hi_addr = lat_q[HI_W-1:0];
endmodule

// File: rtl/mux_addr_decoder_chk.sv
// Checker: settles with the combinational logic and checks the select and
// address rules. Bound to every instance of the top.
module mux_addr_decoder_chk #(
    parameter bit USE_STROBES = 1'b1
) (
    input logic       addr_le,
    input logic [5:0] ma,
    input logic       ce_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [3:0] hi_addr,
    input logic [3:0] sel_n,
    input logic [5:0] lat_q
);
    // Rules evaluated whenever any watched signal settles
    always_comb begin
        if (!$isunknown({addr_le, ma, ce_n, rd_n, wr_n, sel_n, hi_addr, lat_q})) begin
            p_one_low_max_r9: assert ($onehot0(~sel_n));
            if (ce_n)
                p_ce_forces_high_r5: assert (sel_n == 4'hF);
            if (USE_STROBES && rd_n && wr_n)
                p_strobes_idle_r7: assert (sel_n == 4'hF);
            if (!ce_n && (!USE_STROBES || !rd_n || !wr_n))
                p_decode_hits_bank_r4: assert ($countones(~sel_n) == 1 && sel_n[lat_q[5:4]] == 1'b0);
            if (addr_le)
                p_transparent_r1: assert (hi_addr == ma[3:0]);
        end
    end
endmodule

bind mux_addr_decoder mux_addr_decoder_chk #(.USE_STROBES(USE_STROBES)) u_chk (
    .addr_le (addr_le),
    .ma      (ma),
    .ce_n    (ce_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .hi_addr (hi_addr),
    .sel_n   (sel_n),
    .lat_q   (lat_q)
);

// File: tb/test_mux_addr_decoder.sv
// Bench: drives both build variants with the same stimulus, keeps a behavioural
// reference and compares both outputs once per clock, away from the driving edge.
module test_mux_addr_decoder;
    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic       addr_le, ce_n, rd_n, wr_n;
    logic [5:0] ma;
    logic [3:0] hi_a, sel_a, hi_b, sel_b;

    int vectors = 0;
    int fails   = 0;
    int held    = 0;   // reference latch content
    bit done    = 1'b0;

    mux_addr_decoder #(.USE_STROBES(1'b1)) i_mux_addr_decoder (
        .addr_le(addr_le), .ma(ma), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .hi_addr(hi_a), .sel_n(sel_a)
    );

    mux_addr_decoder #(.USE_STROBES(1'b0)) i_mux_addr_decoder_nostb (
        .addr_le(addr_le), .ma(ma), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .hi_addr(hi_b), .sel_n(sel_b)
    );

    // Reference select value for a held address and gate state
    function automatic logic [3:0] ref_sel(input int a, input bit en);
        logic [3:0] s;
        s = 4'hF;
        if (en) s[(a >> 4) & 3] = 1'b0;
        return s;
    endfunction

    // Compares one output against its expected value
    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (ma=%0d le=%b ce_n=%b rd_n=%b wr_n=%b)",
                     req, act, exp, ma, addr_le, ce_n, rd_n, wr_n);
        end
    endtask

    // Applies one input set, updates the reference, then checks at the falling edge
    task automatic apply(input bit le, input int a, input bit ce, input bit rd, input bit wr,
                         input string req);
        @(posedge clk);
        addr_le <= le; ma <= 6'(a); ce_n <= ce; rd_n <= rd; wr_n <= wr;
        if (le) held = a;
        @(negedge clk);
        check({req, " hi_addr/R3"}, hi_a, 4'(held & 15));
        check({req, " sel/R4 R5 R7"}, sel_a, ref_sel(held, !ce && !(rd && wr)));
        check({req, " hi_addr nostb/R3"}, hi_b, 4'(held & 15));
        check({req, " sel nostb/R8"}, sel_b, ref_sel(held, !ce));
        if (($countones(~sel_a) > 1) || ($countones(~sel_b) > 1)) begin
            fails++;
            $display("FAIL R9: actual %b/%b expected at most one low", sel_a, sel_b);
        end
    endtask

    initial begin
        addr_le = 1'b1; ma = '0; ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        held = 0;
        @(negedge clk);
        // Reset state: disabled selects all high after first capture
        check("R5 initial sel", sel_a, 4'hF);
        check("R5 initial sel nostb", sel_b, 4'hF);

        // R1 R4 R5 R7 R8: transparent sweep of every address and gate pattern
        for (int a = 0; a < 64; a++)
            for (int g = 0; g < 8; g++)
                apply(1'b1, a, g[2], g[1], g[0], "R1 transparent");

        // R2 R6: capture one value, then toggle everything with the strobe low
        for (int cap = 0; cap < 64; cap += 9) begin
            apply(1'b1, cap, 1'b0, 1'b0, 1'b1, "R1 capture");
            for (int a = 0; a < 64; a++)
                for (int g = 0; g < 8; g++)
                    apply(1'b0, a ^ cap ^ 6'h2A, g[2], g[1], g[0], "R2 R6 hold");
        end

        // R6: enable toggling alone while holding
        apply(1'b1, 6'h37, 1'b0, 1'b1, 1'b0, "R1 capture");
        for (int k = 0; k < 6; k++)
            apply(1'b0, 6'h08, k[0], 1'b1, 1'b0, "R6 enable toggle");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule